// File: doc/BRIEF.md
# MAC Transmit Pause Controller

This block halts and then restarts data-frame transmission in a full-duplex MAC when the receive side reports a valid PAUSE frame. A single-cycle pulse on `pause_det_i` makes the block raise a graceful stop request to the transmitter. It then waits until the transmitter reports that it has gone idle. At that point it raises a one-cycle interrupt and starts timing the pause in slot times. Once the programmed number of slot times has elapsed, it drops the stop request by itself and transmission resumes. A status bit stays high for the whole time the transmitter is held by a received pause.

The slot-time counter is a single register that is shared with the half-duplex collision backoff timer. The `bo_mode_i` input gives the counter to one of two users. In backoff mode the counter serves a backoff request: `bo_start_i` together with `bo_slots_i` produces a `bo_done_o` pulse after that many slot ticks, and pause detections have no effect. In pause mode the counter belongs to the pause sequencer. All pins are plain control and status signals, and there is no back-pressure at the edge of the block.

Top module: `pause_tx_ctrl`

## Requirements
- R1: While `rst_ni` is low, and on the first cycle after it is released, `tx_stop_req_o`, `pause_irq_o`, `rx_fc_paused_o` and `bo_done_o` are all 0.
- R2: In pause mode (`bo_mode_i`=0), a `pause_det_i` pulse seen while the block is idle sets `tx_stop_req_o` to 1 on the following cycle.
- R3: `pause_irq_o` is a one-cycle pulse. It is raised on the cycle after `tx_idle_i` is first seen high during a stop, and never while the block is still waiting for the transmitter to go idle.
- R4: The pause counter starts from zero when the transmitter stops. Slot ticks that arrive while the block waits for `tx_idle_i` are not counted.
- R5: With a programmed duration D and a slot tick on every cycle, `rx_fc_paused_o` is high for exactly D+1 cycles. `tx_stop_req_o` then falls on the same edge as `rx_fc_paused_o`.
- R6: A duration of zero holds `rx_fc_paused_o` high for exactly one cycle, so the stop is released on the cycle after the transmitter reports idle.
- R7: `rx_fc_paused_o` is high exactly during the paused interval, from the edge after the stop completes until the release. It is never high while `tx_stop_req_o` is low.
- R8: A `pause_det_i` pulse during the paused interval reloads the count to zero. If it arrives in paused cycle j, the paused interval lasts j+D+1 cycles.
- R9: While `bo_mode_i`=1, `pause_det_i` is ignored and `tx_stop_req_o` stays 0.
- R10: In backoff mode, a `bo_start_i` pulse with slot count S yields a one-cycle `bo_done_o` pulse after S slot ticks. With a tick on every cycle, the pulse appears on the (S+2)th cycle after the start edge.
- R11: `tx_stop_req_o` stays high continuously from the cycle after detection until the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bo_mode_i | input | 1 | 1: counter serves collision backoff, 0: counter serves pause timing |
| pause_det_i | input | 1 | One-cycle pulse, valid PAUSE frame received |
| pause_dur_i | input | DUR_W | Pause length in slot times |
| slot_tick_i | input | 1 | One-cycle pulse per slot time |
| tx_idle_i | input | 1 | Transmitter has stopped and is idle |
| bo_start_i | input | 1 | Start a backoff wait (backoff mode only) |
| bo_slots_i | input | BO_W | Backoff wait length in slot times |
| tx_stop_req_o | output | 1 | Graceful stop request to the transmitter |
| pause_irq_o | output | 1 | One-cycle pulse when the transmitter has paused |
| rx_fc_paused_o | output | 1 | Transmitter is held by a received pause |
| bo_done_o | output | 1 | One-cycle pulse when the backoff wait ends |

## Verification
The assertions assume three things about the inputs. `bo_mode_i` changes only while no pause sequence and no backoff wait is in progress. `pause_dur_i` stays stable from detection until release. `bo_slots_i` matters only on the cycle of a start. The random stimulus keeps to these rules: it toggles the mode and redraws the duration and slot count only when its own reference model reports both users idle. All other pins are drawn freely every cycle, including detections during a stop or a pause and detections in backoff mode.

// File: rtl/pause_ctl_pkg.sv
package pause_ctl_pkg;

  typedef enum logic [1:0] {
    PS_IDLE      = 2'd0,
    PS_WAIT_STOP = 2'd1,
    PS_PAUSED    = 2'd2
  } pause_state_e;

  // Command to the shared slot counter: clear wins over increment.
  typedef struct packed {
    logic clr;
    logic inc;
  } slot_cmd_t;

  localparam slot_cmd_t SLOT_HOLD = '{clr: 1'b0, inc: 1'b0};

endpackage

// File: rtl/pause_slot_counter.sv
module pause_slot_counter
  import pause_ctl_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  slot_cmd_t        cmd_i,
  output logic [CNT_W-1:0] cnt_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_o <= '0;
    else if (cmd_i.clr)  cnt_o <= '0;
    else if (cmd_i.inc)  cnt_o <= cnt_o + CNT_W'(1);
  end

  // R4
  cnt_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i.clr |=> (cnt_o == '0));

  // R4
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmd_i.clr && !cmd_i.inc) |=> $stable(cnt_o));

endmodule

// File: rtl/pause_fsm.sv
module pause_fsm
  import pause_ctl_pkg::*;
#(
  parameter int DUR_W = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             det_i,
  input  logic             tx_idle_i,
  input  logic             tick_i,
  input  logic [DUR_W-1:0] dur_i,
  input  logic [CNT_W-1:0] cnt_i,
  output slot_cmd_t        cmd_o,
  output logic             stop_req_o,
  output logic             irq_o,
  output logic             rfc_o
);

  pause_state_e st_q, st_d;
  logic         due;

  assign due = (cnt_i >= CNT_W'(dur_i));

  always_comb begin
    st_d  = st_q;
    cmd_o = SLOT_HOLD;
    case (st_q)
      PS_IDLE: begin
        if (det_i) st_d = PS_WAIT_STOP;
      end
      PS_WAIT_STOP: begin
        cmd_o.clr = 1'b1;
        if (tx_idle_i) st_d = PS_PAUSED;
      end
      PS_PAUSED: begin
        if (det_i)       cmd_o.clr = 1'b1;
        else if (due)    st_d = PS_IDLE;
        else if (tick_i) cmd_o.inc = 1'b1;
      end
      default: st_d = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= PS_IDLE;
      stop_req_o <= 1'b0;
      rfc_o      <= 1'b0;
      irq_o      <= 1'b0;
    end else begin
      st_q       <= st_d;
      stop_req_o <= (st_d != PS_IDLE);
      rfc_o      <= (st_d == PS_PAUSED);
      irq_o      <= (st_q == PS_WAIT_STOP) && (st_d == PS_PAUSED);
    end
  end

  // R2
  detect_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == PS_IDLE && det_i) |=> stop_req_o);

  // R3
  irq_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  // R3
  irq_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $rose(rfc_o));

  // R7
  rfc_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rfc_o |-> stop_req_o);

  // R5
  release_due_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rfc_o) |-> $past(due));

  // R8
  redetect_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == PS_PAUSED && det_i) |=> rfc_o);

endmodule

// File: rtl/backoff_ctl.sv
module backoff_ctl
  import pause_ctl_pkg::*;
#(
  parameter int BO_W  = 10,
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [BO_W-1:0]  slots_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] cnt_i,
  output slot_cmd_t        cmd_o,
  output logic             done_o
);

  logic            run_q;
  logic [BO_W-1:0] tgt_q;
  logic            at_tgt;

  assign at_tgt = (cnt_i == CNT_W'(tgt_q));

  always_comb begin
    cmd_o = SLOT_HOLD;
    if (start_i)                       cmd_o.clr = 1'b1;
    else if (run_q && !at_tgt && tick_i) cmd_o.inc = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      tgt_q  <= '0;
      done_o <= 1'b0;
    end else if (start_i) begin
      run_q  <= 1'b1;
      tgt_q  <= slots_i;
      done_o <= 1'b0;
    end else if (run_q && at_tgt) begin
      run_q  <= 1'b0;
      done_o <= 1'b1;
    end else begin
      done_o <= 1'b0;
    end
  end

  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R10
  done_after_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(run_q));

endmodule

// File: rtl/pause_tx_ctrl.sv
module pause_tx_ctrl
  import pause_ctl_pkg::*;
#(
  parameter int DUR_W = 16,
  parameter int BO_W  = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bo_mode_i,
  input  logic             pause_det_i,
  input  logic [DUR_W-1:0] pause_dur_i,
  input  logic             slot_tick_i,
  input  logic             tx_idle_i,
  input  logic             bo_start_i,
  input  logic [BO_W-1:0]  bo_slots_i,
  output logic             tx_stop_req_o,
  output logic             pause_irq_o,
  output logic             rx_fc_paused_o,
  output logic             bo_done_o
);

  localparam int CNT_W = (DUR_W > BO_W) ? DUR_W : BO_W;

  logic [CNT_W-1:0] cnt;
  slot_cmd_t        ps_cmd, bo_cmd, cnt_cmd;
  logic             det_ok, start_ok;

  // Each user only sees its requests in its own mode.
  assign det_ok   = pause_det_i & ~bo_mode_i;
  assign start_ok = bo_start_i  &  bo_mode_i;
  assign cnt_cmd  = bo_mode_i ? bo_cmd : ps_cmd;

  pause_slot_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cmd_i  (cnt_cmd),
    .cnt_o  (cnt)
  );

  pause_fsm #(.DUR_W(DUR_W), .CNT_W(CNT_W)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .det_i      (det_ok),
    .tx_idle_i  (tx_idle_i),
    .tick_i     (slot_tick_i),
    .dur_i      (pause_dur_i),
    .cnt_i      (cnt),
    .cmd_o      (ps_cmd),
    .stop_req_o (tx_stop_req_o),
    .irq_o      (pause_irq_o),
    .rfc_o      (rx_fc_paused_o)
  );

  backoff_ctl #(.BO_W(BO_W), .CNT_W(CNT_W)) u_bo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_ok),
    .slots_i (bo_slots_i),
    .tick_i  (slot_tick_i),
    .cnt_i   (cnt),
    .cmd_o   (bo_cmd),
    .done_o  (bo_done_o)
  );

  // R9
  bo_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bo_mode_i && pause_det_i && !tx_stop_req_o) |=> !tx_stop_req_o);

  // R4
  pause_start_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_fc_paused_o) |-> (cnt == '0));

endmodule

// File: tb/test_pause_tx_ctrl.sv
`timescale 1ns/1ps
module test_pause_tx_ctrl;
  localparam int DUR_W = 16;
  localparam int BO_W  = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bo_mode = 1'b0, pause_det = 1'b0, slot_tick = 1'b0, tx_idle = 1'b0, bo_start = 1'b0;
  logic [DUR_W-1:0] dur = '0;
  logic [BO_W-1:0]  slots = '0;
  logic stop_req, irq, rfc, bo_done;

  int checks = 0, errors = 0;
  bit cmp_en = 1'b0, finished = 1'b0;

  always #2.5 clk = ~clk;

  pause_tx_ctrl #(.DUR_W(DUR_W), .BO_W(BO_W)) i_pause_tx_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .bo_mode_i(bo_mode), .pause_det_i(pause_det),
    .pause_dur_i(dur), .slot_tick_i(slot_tick), .tx_idle_i(tx_idle),
    .bo_start_i(bo_start), .bo_slots_i(slots), .tx_stop_req_o(stop_req),
    .pause_irq_o(irq), .rx_fc_paused_o(rfc), .bo_done_o(bo_done)
  );

  // Reference model: 0 idle, 1 stopping, 2 paused; remaining-slots formulation.
  int m_st = 0, m_rem = 0, m_brem = 0;
  bit m_run = 0, m_irq = 0, m_done = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_rem = 0; m_run = 0; m_brem = 0; m_irq = 0; m_done = 0;
    end else begin
      m_irq  = 0;
      m_done = 0;
      case (m_st)
        0: if (pause_det && !bo_mode) m_st = 1;
        1: if (tx_idle) begin m_st = 2; m_rem = int'(dur); m_irq = 1; end
        default: begin
          if (pause_det && !bo_mode) m_rem = int'(dur);
          else if (m_rem == 0)       m_st = 0;
          else if (slot_tick)        m_rem = m_rem - 1;
        end
      endcase
      if (bo_mode && bo_start) begin
        m_run = 1; m_brem = int'(slots);
      end else if (m_run) begin
        if (m_brem == 0) begin m_done = 1; m_run = 0; end
        else if (slot_tick) m_brem = m_brem - 1;
      end
    end
  end

  function automatic int exp_len(input int d, input int redet);
    return (redet > 0) ? redet + d + 1 : d + 1;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en) begin
      chk(stop_req == (m_st != 0), "R11 stop request", int'(stop_req), int'(m_st != 0));
      chk(irq == m_irq, "R3 paused interrupt", int'(irq), int'(m_irq));
      chk(rfc == (m_st == 2), "R7 paused status", int'(rfc), int'(m_st == 2));
      chk(bo_done == m_done, "R10 backoff done", int'(bo_done), int'(m_done));
    end
  end

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic run_pause(input int d, input int wait_n, input int redet, input string tag);
    int len, irq_n;
    bit bad_irq;
    len = 0; irq_n = 0; bad_irq = 0;
    dur = DUR_W'(d); slot_tick = 1'b1; tx_idle = 1'b0;
    pause_det = 1'b1;
    cyc();
    pause_det = 1'b0;
    @(negedge clk);
    chk(stop_req == 1'b1, "R2 stop after detect", int'(stop_req), 1);
    if (irq) bad_irq = 1;
    repeat (wait_n) begin
      @(negedge clk);
      if (irq) bad_irq = 1;
    end
    tx_idle = 1'b1;
    for (int i = 0; i < 100; i++) begin
      @(posedge clk);
      #1 pause_det = 1'b0;
      @(negedge clk);
      if (rfc) len++;
      if (irq) irq_n++;
      if (rfc && len == redet) pause_det = 1'b1;
      if (!stop_req) break;
    end
    chk(len == exp_len(d, redet), tag, len, exp_len(d, redet));
    chk(irq_n == 1, "R3 one interrupt per pause", irq_n, 1);
    chk(!bad_irq, "R3 no interrupt while stopping", int'(bad_irq), 0);
    chk(!rfc && !stop_req, "R11 release together", int'(rfc), 0);
    tx_idle = 1'b0; slot_tick = 1'b0;
    cyc(); cyc();
  endtask

  task automatic run_backoff(input int s);
    int k;
    k = 0;
    slot_tick = 1'b1;
    slots = BO_W'(s); bo_start = 1'b1;
    cyc();
    bo_start = 1'b0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      k++;
      if (bo_done) break;
    end
    chk(k == s + 2, "R10 backoff wait length", k, s + 2);
    slot_tick = 1'b0;
    cyc(); cyc();
  endtask

  initial begin
    void'($urandom(32'd1234567));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!stop_req && !irq && !rfc && !bo_done, "R1 reset outputs",
        int'({stop_req, irq, rfc, bo_done}), 0);
    rst_n = 1'b1;
    cmp_en = 1'b1;
    @(negedge clk);
    chk(!stop_req && !irq && !rfc && !bo_done, "R1 after release",
        int'({stop_req, irq, rfc, bo_done}), 0);
    cyc();

    run_pause(3, 4, 0, "R5 pause length");
    run_pause(0, 2, 0, "R6 zero duration");
    run_pause(2, 1, 2, "R8 reload on redetect");
    run_pause(1, 6, 0, "R4 ticks before stop ignored");
    run_pause(4, 0, 5, "R8 redetect at due cycle");

    bo_mode = 1'b1;
    run_backoff(4);
    run_backoff(0);
    pause_det = 1'b1;
    cyc();
    pause_det = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk(!stop_req, "R9 detect ignored in backoff mode", int'(stop_req), 0);
    end
    cyc();
    bo_mode = 1'b0;
    cyc();

    for (int n = 0; n < 4000; n++) begin
      cyc();
      pause_det = 1'b0; bo_start = 1'b0;
      if (m_st == 0 && !m_run && ($urandom % 40) == 0) bo_mode = ~bo_mode;
      if (m_st == 0 && !m_run && ($urandom % 4) == 0) begin
        dur   = DUR_W'($urandom % 6);
        slots = BO_W'($urandom % 6);
      end
      slot_tick = 1'($urandom % 2);
      tx_idle   = (($urandom % 3) != 0);
      pause_det = (($urandom % 7) == 0);
      bo_start  = bo_mode && (($urandom % 9) == 0);
    end
    cyc();
    pause_det = 1'b0; bo_start = 1'b0;
    repeat (3) cyc();

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5.0);
    if (!finished) begin
      errors++;
      $display("FAIL R11 watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule